// File: doc/BRIEF.md
# Earliest-Deadline-First Task Scheduler

This block takes timer-tick handling and the dispatch decision off a processor. It keeps system time in units of scheduler ticks. Periodic tasks are held in two sorted queues. The sleep queue is ordered by each task's next activation time. The ready queue is ordered by each task's absolute deadline.

On every tick a controller moves every task whose activation time has arrived from the sleep queue to the ready queue. Its deadline there is the activation time plus its period, because a task's relative deadline equals its period. The head of the ready queue is the task that should run now. Task ID 0 means idle.

Software talks to the block through a single command stream with valid/ready handshaking, in the manner of a custom-instruction port. The source may hold `cmd_valid` with stable fields for as long as `cmd_ready` is low. A command is taken on a rising clock edge where both are high. `cmd_ready` drops for the tick cycle and for every cycle of the promotion pass that follows it. There is no back-pressure on the response: `rsp_valid` is a one-cycle strobe, and the issuer must accept it.

Top module: `edf_sched`

## Requirements
- R1: After reset `cur_id` is 0, `preempt` is 0, `cmd_ready` is 1, `rsp_valid` is 0 and `now` is 0.
- R2: `now` increases by exactly 1 once every `TICK_DIV` clock cycles and holds its value between ticks.
- R3: Add-task (`cmd_op`=1) accepted while `now` is N puts the task to sleep with activation time N+phase. The task enters the ready queue after the tick on which `now` reaches that time, and not before. Its deadline there is activation time + period.
- R4: Add-task is refused (`rsp_ok`=0) and changes nothing in these cases: the ID is 0, the period is 0, the ID is already held in either queue, or `DEPTH` tasks are already registered.
- R5: `cur_id` is the ID of the ready task with the smallest deadline, or 0 when no task is ready. Among equal deadlines, the task that entered the ready queue first wins.
- R6: Job-done (`cmd_op`=2) for a ready task removes it from the ready queue and returns `rsp_ok`=1. The task sleeps again with next activation = its previous activation + period, which equals the deadline it just had. Job-done for an ID that is not ready returns `rsp_ok`=0 and changes nothing.
- R7: Get-current (`cmd_op`=0) returns `cur_id` in `rsp_id` with `rsp_ok`=1 and records it as the running task. `preempt` is high exactly while `cur_id` differs from the last recorded running task, which is 0 after reset.
- R8: `cmd_ready` is low in the tick cycle and in the cycle after it, and it stays low until the promotion pass finishes.
- R9: Each accepted command yields exactly one `rsp_valid` strobe, in the cycle after acceptance. For add-task and job-done, `rsp_id` echoes the command's ID. Op code 3 returns `rsp_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 get-current, 1 add-task, 2 job-done, 3 no operation |
| cmd_id | input | ID_W | Task ID for add-task and job-done |
| cmd_period | input | TIME_W | Period in ticks, for add-task |
| cmd_phase | input | TIME_W | Ticks from now to the first activation, for add-task |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Command succeeded |
| rsp_id | output | ID_W | Current task (get-current) or echoed ID |
| cur_id | output | ID_W | Task with the earliest deadline, 0 for idle |
| preempt | output | 1 | Current task differs from the last reported one |
| now | output | TIME_W | System time in ticks |

## Verification
The hardest case to reach is a deadline tie in the ready queue. Two tasks must end up with the same absolute deadline even though they were promoted on different ticks. A task must also re-enter the queue through a job-done while another task is still waiting. The stimulus registers three tasks on the same tick, with phases and periods picked so that one completed task's second activation lands on exactly the deadline of a task that has been ready for many ticks. That exposes the first-in-wins rule at the ports. Every add is also checked to have been taken on the same tick, so that every expected activation time is exact.

// File: rtl/edf_pkg.sv
package edf_pkg;
  typedef enum logic [1:0] {
    OP_GET  = 2'd0,
    OP_ADD  = 2'd1,
    OP_DONE = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  typedef enum logic {
    ST_IDLE,
    ST_PROMOTE
  } st_e;
endpackage

// File: rtl/edf_tick_timer.sv
module edf_tick_timer #(
  parameter int TICK_DIV = 5000,
  parameter int TIME_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              tick,
  output logic [TIME_W-1:0] now
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0]  div_q;
  logic [TIME_W-1:0] now_q;

  assign tick = (div_q == DIV_LAST);
  assign now  = now_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      now_q <= '0;
    end else if (tick) begin
      div_q <= '0;
      now_q <= now_q + TIME_W'(1);
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  // R2
  now_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> now == $past(now) + TIME_W'(1));
  // R2
  now_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(now));
endmodule

// File: rtl/edf_sorted_queue.sv
module edf_sorted_queue #(
  parameter int DEPTH = 8,
  parameter int KEY_W = 32,
  parameter int PAY_W = 40,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [KEY_W-1:0] ins_key,
  input  logic [PAY_W-1:0] ins_pay,
  input  logic             pop_en,
  input  logic             rm_en,
  input  logic [ID_W-1:0]  look_id,
  output logic             head_vld,
  output logic [KEY_W-1:0] head_key,
  output logic [PAY_W-1:0] head_pay,
  output logic             hit,
  output logic [KEY_W-1:0] hit_key,
  output logic [PAY_W-1:0] hit_pay
);
  logic [DEPTH-1:0] vld_q;
  logic [KEY_W-1:0] key_q [DEPTH];
  logic [PAY_W-1:0] pay_q [DEPTH];

  logic [DEPTH:0]   gt_dn, vld_dn;
  logic [KEY_W-1:0] key_dn [DEPTH+1];
  logic [PAY_W-1:0] pay_dn [DEPTH+1];
  logic [DEPTH:0]   vld_up;
  logic [KEY_W-1:0] key_up [DEPTH+1];
  logic [PAY_W-1:0] pay_up [DEPTH+1];
  logic [DEPTH-1:0] match, after;

  assign gt_dn[0]  = 1'b0;
  assign vld_dn[0] = 1'b1;
  assign key_dn[0] = '0;
  assign pay_dn[0] = '0;
  assign vld_up[DEPTH] = 1'b0;
  assign key_up[DEPTH] = '0;
  assign pay_up[DEPTH] = '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign gt_dn[i+1]  = vld_q[i] && (key_q[i] > ins_key);
    assign vld_dn[i+1] = vld_q[i];
    assign key_dn[i+1] = key_q[i];
    assign pay_dn[i+1] = pay_q[i];
    assign vld_up[i]   = vld_q[i];
    assign key_up[i]   = key_q[i];
    assign pay_up[i]   = pay_q[i];
    assign match[i]    = vld_q[i] && (pay_q[i][ID_W-1:0] == look_id);
    if (i == 0) begin : g_first
      assign after[i] = match[i];
    end else begin : g_rest
      assign after[i] = match[i] | after[i-1];
    end

    // R5
    packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_dn[i+1] || !vld_up[i+1]);
    // R5
    sorted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[i] && vld_up[i+1]) |-> key_q[i] <= key_up[i+1]);
  end

  always_comb begin
    hit_key = '0;
    hit_pay = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_key |= match[i] ? key_q[i] : '0;
      hit_pay |= match[i] ? pay_q[i] : '0;
    end
  end

  assign hit      = |match;
  assign head_vld = vld_q[0];
  assign head_key = key_q[0];
  assign head_pay = pay_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        key_q[i] <= '0;
        pay_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_en) begin
          if (gt_dn[i]) begin
            vld_q[i] <= vld_dn[i];
            key_q[i] <= key_dn[i];
            pay_q[i] <= pay_dn[i];
          end else if (vld_dn[i] && (gt_dn[i+1] || !vld_q[i])) begin
            vld_q[i] <= 1'b1;
            key_q[i] <= ins_key;
            pay_q[i] <= ins_pay;
          end
        end else if (pop_en || (rm_en && after[i])) begin
          vld_q[i] <= vld_up[i+1];
          key_q[i] <= key_up[i+1];
          pay_q[i] <= pay_up[i+1];
        end
      end
    end
  end
endmodule

// File: rtl/edf_ctrl.sv
module edf_ctrl
  import edf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 32,
  parameter int ID_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [TIME_W-1:0]        now,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [1:0]               cmd_op,
  input  logic [ID_W-1:0]          cmd_id,
  input  logic [TIME_W-1:0]        cmd_period,
  input  logic [TIME_W-1:0]        cmd_phase,
  output logic                     rsp_valid,
  output logic                     rsp_ok,
  output logic [ID_W-1:0]          rsp_id,
  input  logic [ID_W-1:0]          cur_id,
  output logic                     preempt,
  input  logic                     s_head_vld,
  input  logic [TIME_W-1:0]        s_head_key,
  input  logic [TIME_W+ID_W-1:0]   s_head_pay,
  input  logic                     s_hit,
  input  logic [TIME_W-1:0]        s_hit_key,
  input  logic [TIME_W+ID_W-1:0]   s_hit_pay,
  output logic                     s_ins_en,
  output logic [TIME_W-1:0]        s_ins_key,
  output logic [TIME_W+ID_W-1:0]   s_ins_pay,
  output logic                     s_pop_en,
  input  logic [TIME_W-1:0]        r_head_key,
  input  logic                     r_hit,
  input  logic [TIME_W-1:0]        r_hit_key,
  input  logic [TIME_W+ID_W-1:0]   r_hit_pay,
  output logic                     r_ins_en,
  output logic [TIME_W-1:0]        r_ins_key,
  output logic [TIME_W+ID_W-1:0]   r_ins_pay,
  output logic                     r_rm_en
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  st_e             st_q;
  logic            pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ID_W-1:0] run_q;
  op_e             op;
  logic            acc, add_ok, promote_go, pend_d;

  assign op         = op_e'(cmd_op);
  assign cmd_ready  = (st_q == ST_IDLE) && !tick && !pend_q;
  assign acc        = cmd_valid && cmd_ready;
  assign add_ok     = (cmd_id != '0) && (cmd_period != '0) && !s_hit && !r_hit
                      && (cnt_q < CNT_W'(DEPTH));
  assign promote_go = (st_q == ST_PROMOTE) && s_head_vld && (s_head_key <= now);
  assign pend_d     = pend_q | tick;

  always_comb begin
    s_ins_en  = 1'b0;
    s_ins_key = '0;
    s_ins_pay = '0;
    if (acc && op == OP_ADD && add_ok) begin
      s_ins_en  = 1'b1;
      s_ins_key = now + cmd_phase;
      s_ins_pay = {cmd_period, cmd_id};
    end else if (acc && op == OP_DONE && r_hit) begin
      s_ins_en  = 1'b1;
      s_ins_key = r_hit_key;
      s_ins_pay = r_hit_pay;
    end
  end

  assign s_pop_en  = promote_go;
  assign r_ins_en  = promote_go;
  assign r_ins_key = s_head_key + s_head_pay[TIME_W+ID_W-1:ID_W];
  assign r_ins_pay = s_head_pay;
  assign r_rm_en   = acc && (op == OP_DONE);
  assign preempt   = (cur_id != run_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      pend_q    <= 1'b0;
      cnt_q     <= '0;
      run_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_id    <= '0;
    end else begin
      if (st_q == ST_IDLE && pend_d) begin
        st_q   <= ST_PROMOTE;
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_d;
        if (st_q == ST_PROMOTE && !promote_go) st_q <= ST_IDLE;
      end
      rsp_valid <= acc;
      if (acc) begin
        rsp_id <= cmd_id;
        unique case (op)
          OP_GET: begin
            rsp_ok <= 1'b1;
            rsp_id <= cur_id;
            run_q  <= cur_id;
          end
          OP_ADD: begin
            rsp_ok <= add_ok;
            if (add_ok) cnt_q <= cnt_q + CNT_W'(1);
          end
          OP_DONE: rsp_ok <= r_hit;
          default: rsp_ok <= 1'b0;
        endcase
      end
    end
  end

  // R8
  busy_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !cmd_ready);
  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid);
  // R9
  rsp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> !rsp_valid);
  // R5
  promote_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    promote_go |=> r_head_key <= $past(r_ins_key));
  // R3
  sleeper_future_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && s_hit) |-> (s_hit_key > now && s_hit_pay[TIME_W+ID_W-1:ID_W] != '0));
endmodule

// File: rtl/edf_sched.sv
module edf_sched #(
  parameter int ID_W     = 8,
  parameter int TIME_W   = 32,
  parameter int DEPTH    = 8,
  parameter int TICK_DIV = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [TIME_W-1:0] cmd_period,
  input  logic [TIME_W-1:0] cmd_phase,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [ID_W-1:0]   rsp_id,
  output logic [ID_W-1:0]   cur_id,
  output logic              preempt,
  output logic [TIME_W-1:0] now
);
  localparam int PAY_W = TIME_W + ID_W;

  logic              tick;
  logic              s_head_vld, s_hit, s_ins_en, s_pop_en;
  logic [TIME_W-1:0] s_head_key, s_hit_key, s_ins_key;
  logic [PAY_W-1:0]  s_head_pay, s_hit_pay, s_ins_pay;
  logic              r_head_vld, r_hit, r_ins_en, r_rm_en;
  logic [TIME_W-1:0] r_head_key, r_hit_key, r_ins_key;
  logic [PAY_W-1:0]  r_head_pay, r_hit_pay, r_ins_pay;

  assign cur_id = r_head_vld ? r_head_pay[ID_W-1:0] : '0;

  edf_tick_timer #(.TICK_DIV(TICK_DIV), .TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .now(now)
  );

  edf_sorted_queue #(.DEPTH(DEPTH), .KEY_W(TIME_W), .PAY_W(PAY_W), .ID_W(ID_W)) u_sleep (
    .clk(clk), .rst_n(rst_n),
    .ins_en(s_ins_en), .ins_key(s_ins_key), .ins_pay(s_ins_pay),
    .pop_en(s_pop_en), .rm_en(1'b0), .look_id(cmd_id),
    .head_vld(s_head_vld), .head_key(s_head_key), .head_pay(s_head_pay),
    .hit(s_hit), .hit_key(s_hit_key), .hit_pay(s_hit_pay)
  );

  edf_sorted_queue #(.DEPTH(DEPTH), .KEY_W(TIME_W), .PAY_W(PAY_W), .ID_W(ID_W)) u_ready (
    .clk(clk), .rst_n(rst_n),
    .ins_en(r_ins_en), .ins_key(r_ins_key), .ins_pay(r_ins_pay),
    .pop_en(1'b0), .rm_en(r_rm_en), .look_id(cmd_id),
    .head_vld(r_head_vld), .head_key(r_head_key), .head_pay(r_head_pay),
    .hit(r_hit), .hit_key(r_hit_key), .hit_pay(r_hit_pay)
  );

  edf_ctrl #(.DEPTH(DEPTH), .TIME_W(TIME_W), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .now(now),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_id(cmd_id),
    .cmd_period(cmd_period), .cmd_phase(cmd_phase),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_id(rsp_id),
    .cur_id(cur_id), .preempt(preempt),
    .s_head_vld(s_head_vld), .s_head_key(s_head_key), .s_head_pay(s_head_pay),
    .s_hit(s_hit), .s_hit_key(s_hit_key), .s_hit_pay(s_hit_pay),
    .s_ins_en(s_ins_en), .s_ins_key(s_ins_key), .s_ins_pay(s_ins_pay), .s_pop_en(s_pop_en),
    .r_head_key(r_head_key), .r_hit(r_hit), .r_hit_key(r_hit_key), .r_hit_pay(r_hit_pay),
    .r_ins_en(r_ins_en), .r_ins_key(r_ins_key), .r_ins_pay(r_ins_pay), .r_rm_en(r_rm_en)
  );
endmodule

// File: tb/test_edf_sched.sv
module test_edf_sched;
  localparam int ID_W = 8, TIME_W = 16, DEPTH = 4, TICK_DIV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [ID_W-1:0] cmd_id = '0;
  logic [TIME_W-1:0] cmd_period = '0, cmd_phase = '0;
  logic rsp_valid, rsp_ok, preempt;
  logic [ID_W-1:0] rsp_id, cur_id;
  logic [TIME_W-1:0] now;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit exp_ok_q[$];
  logic [ID_W-1:0] exp_id_q[$];
  string exp_tag_q[$];

  always #2.5 clk = ~clk;

  edf_sched #(.ID_W(ID_W), .TIME_W(TIME_W), .DEPTH(DEPTH), .TICK_DIV(TICK_DIV)) i_edf_sched (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_period(cmd_period), .cmd_phase(cmd_phase),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_id(rsp_id),
    .cur_id(cur_id), .preempt(preempt), .now(now)
  );

  task automatic check(input bit cond, input string tag, input int got, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [ID_W-1:0] id,
                      input logic [TIME_W-1:0] per, input logic [TIME_W-1:0] ph,
                      input bit eok, input logic [ID_W-1:0] eid, input string tag,
                      output logic [TIME_W-1:0] acc_now);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_period = per; cmd_phase = ph;
    acc_now = now;
    @(posedge clk);
    exp_ok_q.push_back(eok); exp_id_q.push_back(eid); exp_tag_q.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_now(input logic [TIME_W-1:0] target);
    @(negedge clk);
    while (now < target) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // scoreboard monitor: R9
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_ok_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", int'(rsp_id), -1);
      end else begin
        bit eok;
        logic [ID_W-1:0] eid;
        string tg;
        eok = exp_ok_q.pop_front(); eid = exp_id_q.pop_front(); tg = exp_tag_q.pop_front();
        check(rsp_ok == eok, {tg, " ok"}, int'(rsp_ok), int'(eok));
        check(rsp_id == eid, {tg, " id"}, int'(rsp_id), int'(eid));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TIME_W-1:0] t, n7, n9, tmp, prev;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(cur_id == 0, "R1 cur_id", int'(cur_id), 0);
    check(preempt == 0, "R1 preempt", int'(preempt), 0);
    check(cmd_ready == 1, "R1 cmd_ready", int'(cmd_ready), 1);
    check(rsp_valid == 0 && now == 0, "R1 rsp_valid/now", int'(now), 0);

    // R2: tick spacing
    prev = now;
    while (now == prev) @(negedge clk);
    // R8: busy right after a tick
    check(cmd_ready == 0, "R8 cmd_ready after tick", int'(cmd_ready), 0);
    prev = now; cyc = 0;
    while (now == prev) begin @(negedge clk); cyc++; end
    check(cyc == TICK_DIV, "R2 tick spacing", cyc, TICK_DIV);
    check(now == prev + 1, "R2 step", int'(now), int'(prev) + 1);

    // R4 refusals and R3 registration, all on one tick
    send(2'd1, 8'd0, 16'd10, 16'd3, 1'b0, 8'd0, "R4 id zero", tmp);
    send(2'd1, 8'd5, 16'd10, 16'd3, 1'b1, 8'd5, "R3 add 5", t);
    send(2'd1, 8'd7, 16'd6, 16'd3, 1'b1, 8'd7, "R3 add 7", n7);
    send(2'd1, 8'd9, 16'd20, 16'd1, 1'b1, 8'd9, "R3 add 9", n9);
    send(2'd1, 8'd5, 16'd8, 16'd2, 1'b0, 8'd5, "R4 duplicate", tmp);
    send(2'd1, 8'd13, 16'd0, 16'd2, 1'b0, 8'd13, "R4 zero period", tmp);
    send(2'd3, 8'd4, 16'd0, 16'd0, 1'b0, 8'd4, "R9 no-op", tmp);
    check(n7 == t && n9 == t, "R3 adds on one tick", int'(n9), int'(t));
    check(cur_id == 0, "R3 none ready before activation", int'(cur_id), 0);

    wait_now(t + 1);
    check(cur_id == 9, "R3 task 9 ready", int'(cur_id), 9);
    check(preempt == 1, "R7 preempt raised", int'(preempt), 1);
    send(2'd0, 8'd0, 16'd0, 16'd0, 1'b1, 8'd9, "R7 get 9", tmp);
    @(negedge clk);
    check(preempt == 0, "R7 preempt cleared", int'(preempt), 0);

    wait_now(t + 3);
    check(cur_id == 7, "R5 earliest deadline 7", int'(cur_id), 7);
    check(preempt == 1, "R7 preempt on new head", int'(preempt), 1);
    send(2'd2, 8'd7, 16'd0, 16'd0, 1'b1, 8'd7, "R6 done 7", tmp);
    repeat (2) @(negedge clk);
    check(cur_id == 5, "R6 next after done", int'(cur_id), 5);
    send(2'd2, 8'd3, 16'd0, 16'd0, 1'b0, 8'd3, "R6 done unknown", tmp);
    send(2'd2, 8'd9, 16'd0, 16'd0, 1'b1, 8'd9, "R6 done 9", tmp);
    repeat (2) @(negedge clk);
    check(cur_id == 5, "R6 head kept", int'(cur_id), 5);

    wait_now(t + 9);
    check(cur_id == 5, "R5 7 back with later deadline", int'(cur_id), 5);
    send(2'd2, 8'd5, 16'd0, 16'd0, 1'b1, 8'd5, "R6 done 5", tmp);
    repeat (2) @(negedge clk);
    check(cur_id == 7, "R6 7 takes over", int'(cur_id), 7);
    send(2'd2, 8'd7, 16'd0, 16'd0, 1'b1, 8'd7, "R6 done 7 again", tmp);
    repeat (2) @(negedge clk);
    check(cur_id == 0, "R6 idle when none ready", int'(cur_id), 0);

    // 9 was done at t+3: next act t+21, deadline t+41; 5 back at t+13 (dl t+23)
    wait_now(t + 13);
    check(cur_id == 5, "R6 5 reactivated", int'(cur_id), 5);
    send(2'd2, 8'd5, 16'd0, 16'd0, 1'b1, 8'd5, "R6 done 5 again", tmp);
    // 7 back at t+15 (dl t+21); 5 back at t+23 (dl t+33)
    wait_now(t + 15);
    check(cur_id == 7, "R6 7 reactivated", int'(cur_id), 7);
    // 9 back at t+21 with deadline t+41; 7 next at t+21 after done -> tie check
    send(2'd2, 8'd7, 16'd0, 16'd0, 1'b1, 8'd7, "R6 done 7 third", tmp);
    // 7 act t+21 dl t+27; 9 act t+21 dl t+41; 5 act t+23 dl t+33
    wait_now(t + 23);
    check(cur_id == 7, "R5 earliest among three", int'(cur_id), 7);
    send(2'd2, 8'd7, 16'd0, 16'd0, 1'b1, 8'd7, "R6 done 7 fourth", tmp);
    // 7 act t+27 dl t+33 ties 5 (dl t+33, ready since t+23)
    wait_now(t + 27);
    check(cur_id == 5, "R5 tie goes to earlier entry", int'(cur_id), 5);
    send(2'd0, 8'd0, 16'd0, 16'd0, 1'b1, 8'd5, "R7 get 5", tmp);

    send(2'd1, 8'd11, 16'd50, 16'd100, 1'b1, 8'd11, "R4 fourth task", tmp);
    send(2'd1, 8'd12, 16'd50, 16'd100, 1'b0, 8'd12, "R4 full", tmp);
    repeat (4) @(negedge clk);
    check(exp_ok_q.size() == 0, "R9 all responses seen", exp_ok_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule